// File: doc/BRIEF.md
# Half-Word SHA-512 Sigma Unit

This functional unit serves a 32-bit processor core that runs SHA-512 without native 64-bit registers. Each request carries two 32-bit source words and a 3-bit operation code. The unit joins the two words into one 64-bit value. It applies a fixed mix of 64-bit rotates, or one zero-extended right shift, combines the terms with XOR, and returns the low 32 bits. Six operations are offered: the two round "sum" functions for the low half, and the two message-schedule "sigma" functions in low-half and high-half forms.

A request is legal only when the core reports 32-bit mode and the hash extension is enabled. Operation codes 6 and 7 are also illegal. An illegal request still completes in one cycle. It returns a zero result and raises an illegal flag that the core can turn into an exception. Results are registered, so each request appears on the outputs one clock after it was presented.

Top module: `sha512_half_sigma`

## Requirements
- R1: The 64-bit operand x is formed with `src_a` as bits 31:0 and `src_b` as bits 63:32. The result is bits 31:0 of the combined 64-bit XOR.
- R2: Code 0 (sum0r) returns rotl(x,25) ^ rotl(x,30) ^ rotr(x,28).
- R3: Code 1 (sum1r) returns rotl(x,23) ^ rotr(x,14) ^ rotr(x,18).
- R4: Code 2 (sig0l) returns rotr(x,1) ^ rotr(x,7) ^ rotr(x,8).
- R5: Code 3 (sig1l) returns rotl(x,3) ^ rotr(x,6) ^ rotr(x,19).
- R6: Code 4 (sig0h) returns rotr(x,1) ^ (zero-extended x[31:0] >> 7) ^ rotr(x,8).
- R7: Code 5 (sig1h) returns rotl(x,3) ^ (zero-extended x[31:0] >> 6) ^ rotr(x,19).
- R8: A valid request with code 6 or 7 is illegal.
- R9: A valid request made while `xlen32_mode` or `ext_enable` is low is illegal. Any illegal request yields `out_result` = 0 with `out_illegal` = 1 and `out_valid` = 1.
- R10: `out_valid` equals `in_valid` from the previous clock edge, and each result appears exactly one cycle after its request.
- R11: A synchronous active-high `rst` clears `out_valid`, `out_illegal` and `out_result` at the next edge.
- R12: After a cycle with `in_valid` low, the next cycle has `out_valid` = 0, `out_illegal` = 0 and `out_result` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 3 | Operation code, 0 to 5 legal |
| src_a | input | 32 | First source word, x[31:0] |
| src_b | input | 32 | Second source word, x[63:32] |
| xlen32_mode | input | 1 | Core runs in 32-bit mode |
| ext_enable | input | 1 | Hash extension enabled |
| out_valid | output | 1 | Result strobe, one cycle after request |
| out_result | output | 32 | Low word of the sigma result |
| out_illegal | output | 1 | Request was illegal |

## Verification
The bench builds the unit with the default 32-bit word width. At that width the 64-bit operand is small enough to sweep a single set bit across all 64 positions under every one of the six codes. With a single bit set, every rotate term and the high-half shift term lands at a distinct, checkable position. All-zero, all-one and random operands are added to these patterns. All eight codes are crossed with each combination of the mode and enable inputs, which reaches every illegal cause. Idle cycles and reset are checked between bursts.

// File: rtl/sha512_half_sigma_pkg.sv
package sha512_half_sigma_pkg;

    localparam int unsigned HS_WORD_W = 32;
    localparam int unsigned HS_OP_W   = 3;

    typedef enum logic [HS_OP_W-1:0] {
        HS_SUM0R = 3'd0,
        HS_SUM1R = 3'd1,
        HS_SIG0L = 3'd2,
        HS_SIG1L = 3'd3,
        HS_SIG0H = 3'd4,
        HS_SIG1H = 3'd5
    } hs_op_e;

    localparam int unsigned HS_OP_LAST = 5;

    // Rotation and shift amounts of the six forms
    localparam int unsigned S0R_L1 = 25, S0R_L2 = 30, S0R_R3 = 28;
    localparam int unsigned S1R_L1 = 23, S1R_R2 = 14, S1R_R3 = 18;
    localparam int unsigned G0_R1  = 1,  G0_R2  = 7,  G0_R3  = 8;
    localparam int unsigned G1_L1  = 3,  G1_R2  = 6,  G1_R3  = 19;

endpackage

// File: rtl/hs_legal_check.sv
module hs_legal_check
    import sha512_half_sigma_pkg::*;
#(
    parameter int unsigned OP_W = HS_OP_W
) (
    input  logic [OP_W-1:0] op_sel,
    input  logic            xlen32_mode,
    input  logic            ext_enable,
    output logic            legal
);
    logic code_ok;

    always_comb begin
        code_ok = (32'(op_sel) <= HS_OP_LAST);
        legal   = code_ok && xlen32_mode && ext_enable;
    end
endmodule

// File: rtl/hs_sigma_core.sv
module hs_sigma_core
    import sha512_half_sigma_pkg::*;
#(
    parameter int unsigned WORD_W = HS_WORD_W,
    parameter int unsigned OP_W   = HS_OP_W
) (
    input  logic [OP_W-1:0]   op_sel,
    input  logic [WORD_W-1:0] src_a,
    input  logic [WORD_W-1:0] src_b,
    output logic [WORD_W-1:0] result
);
    localparam int unsigned DW = 2 * WORD_W;

    function automatic logic [DW-1:0] rot_r(input logic [DW-1:0] v, input int unsigned n);
        logic [2*DW-1:0] dbl;
        dbl = {v, v} >> n;
        return dbl[DW-1:0];
    endfunction

    function automatic logic [DW-1:0] rot_l(input logic [DW-1:0] v, input int unsigned n);
        return rot_r(v, DW - n);
    endfunction

    logic [DW-1:0] x;
    logic [DW-1:0] lo_zx;
    logic [DW-1:0] mix;

    always_comb begin
        x     = {src_b, src_a};
        lo_zx = {{WORD_W{1'b0}}, x[WORD_W-1:0]};
        unique case (op_sel)
            HS_SUM0R: mix = rot_l(x, S0R_L1) ^ rot_l(x, S0R_L2) ^ rot_r(x, S0R_R3);
            HS_SUM1R: mix = rot_l(x, S1R_L1) ^ rot_r(x, S1R_R2) ^ rot_r(x, S1R_R3);
            HS_SIG0L: mix = rot_r(x, G0_R1)  ^ rot_r(x, G0_R2)  ^ rot_r(x, G0_R3);
            HS_SIG1L: mix = rot_l(x, G1_L1)  ^ rot_r(x, G1_R2)  ^ rot_r(x, G1_R3);
            HS_SIG0H: mix = rot_r(x, G0_R1)  ^ (lo_zx >> G0_R2) ^ rot_r(x, G0_R3);
            HS_SIG1H: mix = rot_l(x, G1_L1)  ^ (lo_zx >> G1_R2) ^ rot_r(x, G1_R3);
            default:  mix = '0;
        endcase
        result = mix[WORD_W-1:0];
    end
endmodule

// File: rtl/sha512_half_sigma.sv
module sha512_half_sigma
    import sha512_half_sigma_pkg::*;
#(
    parameter int unsigned WORD_W = HS_WORD_W,
    parameter int unsigned OP_W   = HS_OP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [WORD_W-1:0] src_a,
    input  logic [WORD_W-1:0] src_b,
    input  logic              xlen32_mode,
    input  logic              ext_enable,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_result,
    output logic              out_illegal
);
    typedef struct packed {
        logic              valid;
        logic              illegal;
        logic [WORD_W-1:0] result;
    } hs_state_t;

    hs_state_t         state_d, state_q;
    logic              legal;
    logic [WORD_W-1:0] core_res;

    hs_legal_check #(.OP_W(OP_W)) u_legal (
        .op_sel      (op_sel),
        .xlen32_mode (xlen32_mode),
        .ext_enable  (ext_enable),
        .legal       (legal)
    );

    hs_sigma_core #(.WORD_W(WORD_W), .OP_W(OP_W)) u_core (
        .op_sel (op_sel),
        .src_a  (src_a),
        .src_b  (src_b),
        .result (core_res)
    );

    always_comb begin
        state_d.valid   = in_valid;
        state_d.illegal = in_valid && !legal;
        state_d.result  = (in_valid && legal) ? core_res : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid   = state_q.valid;
    assign out_illegal = state_q.illegal;
    assign out_result  = state_q.result;
endmodule

// File: rtl/hs_sigma_checker.sv
module hs_sigma_checker #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned OP_W   = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [OP_W-1:0]   op_sel,
    input logic              xlen32_mode,
    input logic              ext_enable,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_result,
    input logic              out_illegal
);
    p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_illegal && out_result == '0));

    p_bad_code_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && 32'(op_sel) > 5) |=> out_illegal);

    p_disabled_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (!xlen32_mode || !ext_enable)) |=> (out_illegal && out_result == '0));

    p_illegal_zero_r9: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (out_valid && out_result == '0));

    p_reset_clear_r11: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_illegal && out_result == '0));
endmodule

bind sha512_half_sigma hs_sigma_checker #(.WORD_W(WORD_W), .OP_W(OP_W)) u_checker (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .op_sel      (op_sel),
    .xlen32_mode (xlen32_mode),
    .ext_enable  (ext_enable),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_illegal (out_illegal)
);

// File: tb/sha512_half_sigma_bench.sv
module sha512_half_sigma_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        xlen32_mode = 1'b1;
    logic        ext_enable = 1'b1;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_illegal;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sha512_half_sigma u_sha512_half_sigma (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .src_a(src_a), .src_b(src_b), .xlen32_mode(xlen32_mode),
        .ext_enable(ext_enable), .out_valid(out_valid),
        .out_result(out_result), .out_illegal(out_illegal)
    );

    function automatic logic [63:0] mr(input logic [63:0] v, input int n);
        return (v >> n) | (v << (64 - n));
    endfunction

    function automatic logic [63:0] ml(input logic [63:0] v, input int n);
        return (v << n) | (v >> (64 - n));
    endfunction

    function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] x, z, r;
        x = {b, a};
        z = 64'(a);
        case (op)
            3'd0: r = ml(x, 25) ^ ml(x, 30) ^ mr(x, 28);
            3'd1: r = ml(x, 23) ^ mr(x, 14) ^ mr(x, 18);
            3'd2: r = mr(x, 1) ^ mr(x, 7) ^ mr(x, 8);
            3'd3: r = ml(x, 3) ^ mr(x, 6) ^ mr(x, 19);
            3'd4: r = mr(x, 1) ^ (z >> 7) ^ mr(x, 8);
            3'd5: r = ml(x, 3) ^ (z >> 6) ^ mr(x, 19);
            default: r = 64'd0;
        endcase
        return r[31:0];
    endfunction

    function automatic string op_req(input logic [2:0] op);
        case (op)
            3'd0: return "R2/R1";
            3'd1: return "R3/R1";
            3'd2: return "R4/R1";
            3'd3: return "R5/R1";
            3'd4: return "R6/R1";
            3'd5: return "R7/R1";
            default: return "R8";
        endcase
    endfunction

    task automatic check3(input string req, input logic v, input logic ill, input logic [31:0] res);
        checks++;
        if (out_valid !== v || out_illegal !== ill || out_result !== res) begin
            errors++;
            $display("FAIL %s: got valid=%b illegal=%b result=%h, expected valid=%b illegal=%b result=%h",
                     req, out_valid, out_illegal, out_result, v, ill, res);
        end
    endtask

    // one request, result sampled one cycle later (R10)
    task automatic run_req(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                           input logic mode, input logic en);
        logic        bad;
        logic [31:0] exp;
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; src_a = a; src_b = b;
        xlen32_mode = mode; ext_enable = en;
        bad = (op > 3'd5) || !mode || !en;
        exp = bad ? 32'd0 : model(op, a, b);
        @(posedge clk);
        #1;
        if (bad) check3((op > 3'd5) ? "R8" : "R9", 1'b1, 1'b1, 32'd0);
        else     check3(op_req(op), 1'b1, 1'b0, exp);
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        in_valid = 1'b0; src_a = 32'hFFFF_FFFF; src_b = 32'hFFFF_FFFF;
        @(posedge clk);
        #1;
        check3("R12", 1'b0, 1'b0, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check3("R11", 1'b0, 1'b0, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int op = 0; op < 6; op++) begin
            run_req(3'(op), 32'd0, 32'd0, 1'b1, 1'b1);
            run_req(3'(op), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1);
            run_req(3'(op), 32'hFFFF_FFFF, 32'd0, 1'b1, 1'b1);
            run_req(3'(op), 32'd0, 32'hFFFF_FFFF, 1'b1, 1'b1);
            for (int bit_i = 0; bit_i < 64; bit_i++) begin
                logic [63:0] one;
                one = 64'd1 << bit_i;
                run_req(3'(op), one[31:0], one[63:32], 1'b1, 1'b1);
            end
            for (int k = 0; k < 40; k++)
                run_req(3'(op), $urandom, $urandom, 1'b1, 1'b1);
        end

        // R8 and R9: every code against every mode/enable combination
        for (int op = 0; op < 8; op++)
            for (int me = 0; me < 4; me++)
                run_req(3'(op), 32'h1234_5678, 32'h9ABC_DEF0, me[1], me[0]);

        // R12: idle after a request, then back to back again (R10)
        idle_cycle();
        run_req(3'd2, 32'hDEAD_BEEF, 32'h0BAD_F00D, 1'b1, 1'b1);
        idle_cycle();
        idle_cycle();

        // R11: reset in the middle of traffic clears the outputs
        @(negedge clk);
        in_valid = 1'b1; op_sel = 3'd0; src_a = 32'hFFFF_0000; src_b = 32'h0000_FFFF;
        xlen32_mode = 1'b1; ext_enable = 1'b1; rst = 1'b1;
        @(posedge clk);
        #1;
        check3("R11", 1'b0, 1'b0, 32'd0);
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        run_req(3'd7, 32'h1, 32'h1, 1'b1, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule